// File: doc/BRIEF.md
# Monitor User-Enable Register with Privilege Trap Arbitration

This block holds one 32-bit control word whose bit 0 lets the least privileged software level reach a set of activity monitors. It also decides the fate of each coprocessor-style access aimed at that word. An access arrives as a one-cycle strobe carrying the decoded encoding fields, a read/write flag and write data. The block looks at the current privilege level (0 to 3), two required feature flags, and the state of levels 2 and 3: present, enabled, wide or narrow execution state, and host mode. It also takes the trap-control bits owned by those levels. From these it returns one of three results. The access completes, the access is undefined, or the access traps to level 2 or 3.

A trap result carries the target level, a routing style and an 8-bit syndrome class. Routing style 0 means the wide-state system-access trap. Routing style 1 means the narrow-state hypervisor trap. All results are registered and appear one cycle after the strobe. Taking the exception and running the counters are left to the surrounding core.

Top module: `uen_access_gate`

## Requirements
- R1: An access is recognised only when `acc_coproc`=4'b1111, `acc_opc1`=3'b000, `acc_crn`=4'b1101, `acc_crm`=4'b0010 and `acc_opc2`=3'b011. A recognised strobe gives `rsp_valid`=1 in the next cycle. A strobe with any other encoding, or no strobe, gives `rsp_valid`=0 and changes nothing.
- R2: After synchronous reset, `rsp_valid`, `rsp_ok`, `rsp_undef` and `rsp_trap` are 0 and `mon_enable` is 0.
- R3: Only bit 0 of the register is stored, and it drives `mon_enable`. A completed read returns {31'b0, bit0}. Bits 31:1 always read 0 and ignore writes. `rsp_rdata` is 0 for every other result.
- R4: If `feat_monitor` or `feat_narrow_isa` is 0, every recognised access is undefined.
- R5: With both features present, any access from level 3 completes, and any write from level 0 is undefined.
- R6: For level-0 reads and for level-1 reads and writes, the first match wins in this order:
  1. early level-3 undefined (level-3 access trap set and `l3_undef_prio` set);
  2. level-2 group-13 trap;
  3. level-2 monitor trap;
  4. level-3 access trap.
  If none matches, the access completes.
- R7: Each level-2 check is taken only when `l2_enabled` is set. In wide state (`l2_wide_impl`=1, `l2_narrow`=0) it uses the `l2w_*` bits and routes with style 0. In narrow state (`l2_narrow_impl`=1, `l2_narrow`=1) it uses the `l2n_*` bits and routes with style 1. Either way the target level is 2 and the syndrome is 8'h03. The wide-state group-13 check is skipped for level-0 accesses while `l0_host` is 1.
- R8: Accesses from level 2 see only the two level-3 checks, early undefined first.
- R9: When the level-3 access trap decides the result in the last check, the result is undefined if `l3_undef` is 1. Otherwise it traps to level 3 with style 0 and syndrome 8'h03.
- R10: Level-3 checks apply only when `l3_present`=1, `l3_wide_impl`=1 and `l3_narrow`=0.
- R11: A response asserts exactly one of ok, undefined and trap. Level, route and syndrome are 0 for any non-trap result. The stored bit changes only on a completed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_coproc | input | 4 | Coprocessor field |
| acc_opc1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register field |
| acc_crm | input | 4 | Secondary register field |
| acc_opc2 | input | 3 | Second opcode field |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data |
| cur_level | input | 2 | Current privilege level |
| feat_monitor | input | 1 | Monitor feature present |
| feat_narrow_isa | input | 1 | Narrow execution state supported |
| l2_enabled | input | 1 | Level 2 enabled for this context |
| l2_wide_impl | input | 1 | Level 2 implemented in wide state |
| l2_narrow_impl | input | 1 | Level 2 implemented in narrow state |
| l2_narrow | input | 1 | Level 2 currently in narrow state |
| l3_present | input | 1 | Level 3 exists |
| l3_wide_impl | input | 1 | Level 3 implemented in wide state |
| l3_narrow | input | 1 | Level 3 currently in narrow state |
| l0_host | input | 1 | Level 0 running in host mode |
| l3_undef_prio | input | 1 | Level-3 undefined takes priority |
| l3_undef | input | 1 | Level-3 trap is reported as undefined |
| l3_acc_trap | input | 1 | Level-3 monitor access trap bit |
| l2w_grp_trap | input | 1 | Level-2 group-13 trap, wide set |
| l2n_grp_trap | input | 1 | Level-2 group-13 trap, narrow set |
| l2w_mon_trap | input | 1 | Level-2 monitor trap, wide set |
| l2n_mon_trap | input | 1 | Level-2 monitor trap, narrow set |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Access completed |
| rsp_undef | output | 1 | Access undefined |
| rsp_trap | output | 1 | Access trapped |
| rsp_level | output | 2 | Trap target level |
| rsp_route | output | 1 | 0 = system-access trap, 1 = hypervisor trap |
| rsp_syndrome | output | 8 | Syndrome class |
| rsp_rdata | output | 32 | Read data |
| mon_enable | output | 1 | Stored enable bit |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a mask that keeps only bit 0, and syndrome 8'h03. The first sweep covers every combination of level, direction, level-2 state, host mode and all trap bits, so every order of competing traps in the chain is reached. A second sweep toggles the implementation and feature flags, which reaches the gating of each level-2 form and the level-3 checks. A reference model tracks the stored bit across the writes that complete during both sweeps. Single-bit corruptions of each encoding field confirm that such accesses get no response.

// File: rtl/uen_gate_pkg.sv
// Package: shared result types for the user-enable access gate.
// Assumes consumers treat VERD_NONE as "no decision" only internally.
package uen_gate_pkg;

    typedef enum logic [1:0] {
        VERD_OK    = 2'd0,
        VERD_UNDEF = 2'd1,
        VERD_TRAP  = 2'd2,
        VERD_NONE  = 2'd3
    } verdict_e;

    localparam logic ROUTE_SYS = 1'b0;  // wide-state system-access trap
    localparam logic ROUTE_HYP = 1'b1;  // narrow-state hypervisor trap

    typedef struct packed {
        verdict_e   verdict;
        logic [1:0] level;
        logic       route;
    } decision_t;

endpackage

// File: rtl/uen_enc_match.sv
// Module: compares the decoded access fields against the register's fixed
// encoding. Assumes the fields are stable while the strobe is high.
module uen_enc_match #(
    parameter int          CP_W   = 4,
    parameter int          OP1_W  = 3,
    parameter int          CRN_W  = 4,
    parameter int          CRM_W  = 4,
    parameter int          OP2_W  = 3,
    parameter logic [CP_W-1:0]  CP_VAL  = 4'b1111,
    parameter logic [OP1_W-1:0] OP1_VAL = 3'b000,
    parameter logic [CRN_W-1:0] CRN_VAL = 4'b1101,
    parameter logic [CRM_W-1:0] CRM_VAL = 4'b0010,
    parameter logic [OP2_W-1:0] OP2_VAL = 3'b011
) (
    input  logic [CP_W-1:0]  coproc,
    input  logic [OP1_W-1:0] opc1,
    input  logic [CRN_W-1:0] crn,
    input  logic [CRM_W-1:0] crm,
    input  logic [OP2_W-1:0] opc2,
    output logic             hit
);
    localparam int N_FIELDS = 5;

    logic [N_FIELDS-1:0] field_eq;

    // Per-field equality, then all fields must agree.
    always_comb begin
        field_eq[0] = (coproc == CP_VAL);
        field_eq[1] = (opc1   == OP1_VAL);
        field_eq[2] = (crn    == CRN_VAL);
        field_eq[3] = (crm    == CRM_VAL);
        field_eq[4] = (opc2   == OP2_VAL);
        hit         = &field_eq;
    end
endmodule

// File: rtl/uen_trap_chain.sv
// Module: fixed-priority trap arbitration for one access. Purely combinational.
// Assumes cur_level is 0..3 and that flags describe the current context.
module uen_trap_chain
    import uen_gate_pkg::*;
(
    input  logic [1:0] lvl,
    input  logic       is_write,
    input  logic       feat_monitor,
    input  logic       feat_narrow_isa,
    input  logic       l2_enabled,
    input  logic       l2_wide_impl,
    input  logic       l2_narrow_impl,
    input  logic       l2_narrow,
    input  logic       l3_present,
    input  logic       l3_wide_impl,
    input  logic       l3_narrow,
    input  logic       l0_host,
    input  logic       l3_undef_prio,
    input  logic       l3_undef,
    input  logic       l3_acc_trap,
    input  logic       l2w_grp_trap,
    input  logic       l2n_grp_trap,
    input  logic       l2w_mon_trap,
    input  logic       l2n_mon_trap,
    output decision_t  dec
);
    logic l3_gate, l2w_form, l2n_form;
    logic early_undef, late_trap;
    logic w_grp_hit, n_grp_hit, w_mon_hit, n_mon_hit;

    // Context qualifiers: which forms of each check are live.
    always_comb begin
        l3_gate     = l3_present & l3_wide_impl & ~l3_narrow;
        l2w_form    = l2_enabled & l2_wide_impl & ~l2_narrow;
        l2n_form    = l2_enabled & l2_narrow_impl & l2_narrow;
        early_undef = l3_gate & l3_undef_prio & l3_acc_trap;
        late_trap   = l3_gate & l3_acc_trap;
        w_grp_hit   = l2w_form & l2w_grp_trap & ~((lvl == 2'd0) & l0_host);
        n_grp_hit   = l2n_form & l2n_grp_trap;
        w_mon_hit   = l2w_form & l2w_mon_trap;
        n_mon_hit   = l2n_form & l2n_mon_trap;
    end

    // Priority chain: first matching check decides the result.
    always_comb begin
        dec = '{verdict: VERD_OK, level: 2'd0, route: ROUTE_SYS};
        if (!(feat_monitor && feat_narrow_isa)) begin
            dec.verdict = VERD_UNDEF;
        end else if (lvl == 2'd3) begin
            dec.verdict = VERD_OK;
        end else if (lvl == 2'd2) begin
            if (early_undef) begin
                dec.verdict = VERD_UNDEF;
            end else if (late_trap) begin
                if (l3_undef) dec.verdict = VERD_UNDEF;
                else          dec = '{verdict: VERD_TRAP, level: 2'd3, route: ROUTE_SYS};
            end
        end else if ((lvl == 2'd0) && is_write) begin
            dec.verdict = VERD_UNDEF;
        end else if (early_undef) begin
            dec.verdict = VERD_UNDEF;
        end else if (w_grp_hit) begin
            dec = '{verdict: VERD_TRAP, level: 2'd2, route: ROUTE_SYS};
        end else if (n_grp_hit) begin
            dec = '{verdict: VERD_TRAP, level: 2'd2, route: ROUTE_HYP};
        end else if (w_mon_hit) begin
            dec = '{verdict: VERD_TRAP, level: 2'd2, route: ROUTE_SYS};
        end else if (n_mon_hit) begin
            dec = '{verdict: VERD_TRAP, level: 2'd2, route: ROUTE_HYP};
        end else if (late_trap) begin
            if (l3_undef) dec.verdict = VERD_UNDEF;
            else          dec = '{verdict: VERD_TRAP, level: 2'd3, route: ROUTE_SYS};
        end
    end
endmodule

// File: rtl/uen_ctrl_reg.sv
// Module: the storage word. Only bits set in RW_MASK are kept; others read 0.
// Assumes wr_en is asserted only for completed writes.
module uen_ctrl_reg #(
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] RW_MASK = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              enable_bit
);
    logic [DATA_W-1:0] reg_q;

    // Store writable bits on a committed write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     reg_q <= '0;
        else if (wr_en) reg_q <= wr_data & RW_MASK;
    end

    // Expose masked content and the enable flag.
    always_comb begin
        rd_data    = reg_q & RW_MASK;
        enable_bit = reg_q[0];
    end

    // R11
    reg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q != $past(reg_q)) |-> $past(wr_en));
endmodule

// File: rtl/uen_access_gate.sv
// Module: top of the user-enable access gate. Matches the encoding, runs the
// trap chain, registers the one-hot response one cycle after the strobe and
// commits completed writes. Assumes at most one access per cycle.
module uen_access_gate
    import uen_gate_pkg::*;
#(
    parameter int         DATA_W   = 32,
    parameter int         SYN_W    = 8,
    parameter logic [SYN_W-1:0] SYN_CODE = 8'h03,
    parameter logic [DATA_W-1:0] RW_MASK = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [3:0]        acc_coproc,
    input  logic [2:0]        acc_opc1,
    input  logic [3:0]        acc_crn,
    input  logic [3:0]        acc_crm,
    input  logic [2:0]        acc_opc2,
    input  logic              acc_write,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [1:0]        cur_level,
    input  logic              feat_monitor,
    input  logic              feat_narrow_isa,
    input  logic              l2_enabled,
    input  logic              l2_wide_impl,
    input  logic              l2_narrow_impl,
    input  logic              l2_narrow,
    input  logic              l3_present,
    input  logic              l3_wide_impl,
    input  logic              l3_narrow,
    input  logic              l0_host,
    input  logic              l3_undef_prio,
    input  logic              l3_undef,
    input  logic              l3_acc_trap,
    input  logic              l2w_grp_trap,
    input  logic              l2n_grp_trap,
    input  logic              l2w_mon_trap,
    input  logic              l2n_mon_trap,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              rsp_undef,
    output logic              rsp_trap,
    output logic [1:0]        rsp_level,
    output logic              rsp_route,
    output logic [SYN_W-1:0]  rsp_syndrome,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mon_enable
);
    logic              enc_hit;
    logic              take;
    logic              commit_wr;
    decision_t         dec;
    logic [DATA_W-1:0] cur_word;

    uen_enc_match u_match (
        .coproc (acc_coproc),
        .opc1   (acc_opc1),
        .crn    (acc_crn),
        .crm    (acc_crm),
        .opc2   (acc_opc2),
        .hit    (enc_hit)
    );

    uen_trap_chain u_chain (
        .lvl             (cur_level),
        .is_write        (acc_write),
        .feat_monitor    (feat_monitor),
        .feat_narrow_isa (feat_narrow_isa),
        .l2_enabled      (l2_enabled),
        .l2_wide_impl    (l2_wide_impl),
        .l2_narrow_impl  (l2_narrow_impl),
        .l2_narrow       (l2_narrow),
        .l3_present      (l3_present),
        .l3_wide_impl    (l3_wide_impl),
        .l3_narrow       (l3_narrow),
        .l0_host         (l0_host),
        .l3_undef_prio   (l3_undef_prio),
        .l3_undef        (l3_undef),
        .l3_acc_trap     (l3_acc_trap),
        .l2w_grp_trap    (l2w_grp_trap),
        .l2n_grp_trap    (l2n_grp_trap),
        .l2w_mon_trap    (l2w_mon_trap),
        .l2n_mon_trap    (l2n_mon_trap),
        .dec             (dec)
    );

    // Qualify the strobe and decide whether a write commits.
    always_comb begin
        take      = acc_valid & enc_hit;
        commit_wr = take & acc_write & (dec.verdict == VERD_OK);
    end

    uen_ctrl_reg #(
        .DATA_W  (DATA_W),
        .RW_MASK (RW_MASK)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (commit_wr),
        .wr_data    (acc_wdata),
        .rd_data    (cur_word),
        .enable_bit (mon_enable)
    );

    // Register the response fields one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !take) begin
            rsp_valid    <= 1'b0;
            rsp_ok       <= 1'b0;
            rsp_undef    <= 1'b0;
            rsp_trap     <= 1'b0;
            rsp_level    <= 2'd0;
            rsp_route    <= 1'b0;
            rsp_syndrome <= '0;
            rsp_rdata    <= '0;
        end else begin
            rsp_valid    <= 1'b1;
            rsp_ok       <= (dec.verdict == VERD_OK);
            rsp_undef    <= (dec.verdict == VERD_UNDEF);
            rsp_trap     <= (dec.verdict == VERD_TRAP);
            rsp_level    <= (dec.verdict == VERD_TRAP) ? dec.level : 2'd0;
            rsp_route    <= (dec.verdict == VERD_TRAP) ? dec.route : 1'b0;
            rsp_syndrome <= (dec.verdict == VERD_TRAP) ? SYN_CODE : '0;
            rsp_rdata    <= ((dec.verdict == VERD_OK) && !acc_write) ? cur_word : '0;
        end
    end

    // R11
    resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_ok, rsp_undef, rsp_trap}) == 1));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ({rsp_ok, rsp_undef, rsp_trap} == 3'b000));
    // R1
    resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc_valid));
    // R7
    trap_syndrome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_syndrome == SYN_CODE && rsp_level >= 2'd2));
    // R5
    l0_write_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && enc_hit && acc_write && cur_level == 2'd0) |=> rsp_undef);
    // R5
    l3_always_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && enc_hit && cur_level == 2'd3 && feat_monitor && feat_narrow_isa)
        |=> rsp_ok);
    // R8
    l2_only_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap && $past(cur_level) == 2'd2) |-> (rsp_level == 2'd3));
endmodule

// File: tb/uen_access_gate_test.sv
module uen_access_gate_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic acc_valid = 0, acc_write = 0;
    logic [3:0] acc_coproc = 4'b1111, acc_crn = 4'b1101, acc_crm = 4'b0010;
    logic [2:0] acc_opc1 = 3'b000, acc_opc2 = 3'b011;
    logic [31:0] acc_wdata = 0;
    logic [1:0] cur_level = 0;
    logic feat_monitor = 1, feat_narrow_isa = 1;
    logic l2_enabled = 0, l2_wide_impl = 1, l2_narrow_impl = 1, l2_narrow = 0;
    logic l3_present = 1, l3_wide_impl = 1, l3_narrow = 0, l0_host = 0;
    logic l3_undef_prio = 0, l3_undef = 0, l3_acc_trap = 0;
    logic l2w_grp_trap = 0, l2n_grp_trap = 0, l2w_mon_trap = 0, l2n_mon_trap = 0;

    logic rsp_valid, rsp_ok, rsp_undef, rsp_trap, rsp_route, mon_enable;
    logic [1:0] rsp_level;
    logic [7:0] rsp_syndrome;
    logic [31:0] rsp_rdata;

    uen_access_gate uut (.*);

    int checks = 0, failures = 0;
    logic en_m = 0;
    bit done = 0;

    // Reference model from the requirements: kind 0 ok, 1 undef, 2 trap.
    function automatic void predict(output int kind, output logic [1:0] lv,
                                    output logic rt, output string tag);
        logic g3, w2, n2, early, late;
        g3 = l3_present & l3_wide_impl & ~l3_narrow;
        w2 = l2_enabled & l2_wide_impl & ~l2_narrow;
        n2 = l2_enabled & l2_narrow_impl & l2_narrow;
        early = g3 & l3_undef_prio & l3_acc_trap;
        late = g3 & l3_acc_trap;
        kind = 0; lv = 0; rt = 0; tag = "R6";
        if (!(feat_monitor & feat_narrow_isa)) begin kind = 1; tag = "R4"; end
        else if (cur_level == 3) tag = "R5";
        else if (cur_level == 2) begin
            tag = "R8";
            if (early) kind = 1;
            else if (late) begin
                tag = "R9";
                if (l3_undef) kind = 1; else begin kind = 2; lv = 3; end
            end
        end else if (cur_level == 0 && acc_write) begin kind = 1; tag = "R5"; end
        else if (early) kind = 1;
        else if (w2 & l2w_grp_trap & !(cur_level == 0 && l0_host)) begin
            kind = 2; lv = 2; tag = "R7";
        end else if (n2 & l2n_grp_trap) begin kind = 2; lv = 2; rt = 1; tag = "R7"; end
        else if (w2 & l2w_mon_trap) begin kind = 2; lv = 2; tag = "R7"; end
        else if (n2 & l2n_mon_trap) begin kind = 2; lv = 2; rt = 1; tag = "R7"; end
        else if (late) begin
            tag = "R9";
            if (l3_undef) kind = 1; else begin kind = 2; lv = 3; end
        end
    endfunction

    // Issue one matching access (inputs already set), check at next negedge.
    task automatic do_acc(input string tag_over);
        int k; logic [1:0] lv; logic rt; string tag;
        logic [3:0] got, exp;
        logic [31:0] exp_rd;
        predict(k, lv, rt, tag);
        if (tag_over != "") tag = tag_over;
        exp_rd = (k == 0 && !acc_write) ? {31'b0, en_m} : 32'b0;
        acc_valid = 1;
        @(negedge clk);
        acc_valid = 0;
        if (k == 0 && acc_write) en_m = acc_wdata[0];
        got = {rsp_valid, rsp_ok, rsp_undef, rsp_trap};
        exp = {1'b1, k == 0, k == 1, k == 2};
        checks++;
        if (got !== exp || rsp_level !== lv || rsp_route !== rt ||
            rsp_syndrome !== (k == 2 ? 8'h03 : 8'h00) || rsp_rdata !== exp_rd ||
            mon_enable !== en_m) begin
            failures++;
            $display("FAIL %s R11 lvl=%0d wr=%0b: got v/ok/un/tr=%b lv=%0d rt=%b syn=%h rd=%h en=%b exp %b lv=%0d rt=%b rd=%h en=%b",
                     tag, cur_level, acc_write, got, rsp_level, rsp_route, rsp_syndrome,
                     rsp_rdata, mon_enable, exp, lv, rt, exp_rd, en_m);
        end
    endtask

    task automatic check_quiet(input string tag);
        @(negedge clk);
        acc_valid = 0;
        checks++;
        if (rsp_valid !== 0 || {rsp_ok, rsp_undef, rsp_trap} !== 3'b000 || mon_enable !== en_m) begin
            failures++;
            $display("FAIL %s: got valid=%b flags=%b en=%b exp valid=0 flags=000 en=%b",
                     tag, rsp_valid, {rsp_ok, rsp_undef, rsp_trap}, mon_enable, en_m);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R2: reset state
        checks++;
        if (rsp_valid !== 0 || mon_enable !== 0 || {rsp_ok, rsp_undef, rsp_trap} !== 0) begin
            failures++;
            $display("FAIL R2: got valid=%b en=%b exp 0 0", rsp_valid, mon_enable);
        end
        rst_n = 1;
        @(negedge clk);

        // R3: only bit 0 stored; upper bits ignored on write and read as zero
        cur_level = 3; acc_write = 1; acc_wdata = 32'hFFFF_FFFF; do_acc("R3");
        acc_write = 0; do_acc("R3");
        acc_write = 1; acc_wdata = 32'hFFFF_FFFE; do_acc("R3");
        acc_write = 0; do_acc("R3");
        acc_write = 1; acc_wdata = 32'h8000_0001; do_acc("R3");

        // R1: no strobe gives no response
        acc_write = 1; acc_wdata = 0; check_quiet("R1");
        // R1: each single-bit corruption of the encoding is ignored
        for (int f = 0; f < 5; f++) begin
            for (int b = 0; b < 4; b++) begin
                if (b < 3 || f == 0 || f == 2 || f == 3) begin
                    case (f)
                        0: acc_coproc[b] = ~acc_coproc[b];
                        1: acc_opc1[b]   = ~acc_opc1[b];
                        2: acc_crn[b]    = ~acc_crn[b];
                        3: acc_crm[b]    = ~acc_crm[b];
                        default: acc_opc2[b] = ~acc_opc2[b];
                    endcase
                    acc_valid = 1;
                    check_quiet("R1");
                    acc_coproc = 4'b1111; acc_opc1 = 3'b000; acc_crn = 4'b1101;
                    acc_crm = 4'b0010; acc_opc2 = 3'b011;
                end
            end
        end

        // R6 R7 R8 R9: full sweep of level, direction, level-2 state and trap bits
        for (int i = 0; i < (1 << 15); i++) begin
            cur_level = i[1:0]; acc_write = i[2]; l2_enabled = i[3]; l2_narrow = i[4];
            l3_wide_impl = i[5]; l3_narrow = i[6]; l0_host = i[7]; l3_undef_prio = i[8];
            l3_undef = i[9]; l3_acc_trap = i[10]; l2w_grp_trap = i[11];
            l2n_grp_trap = i[12]; l2w_mon_trap = i[13]; l2n_mon_trap = i[14];
            acc_wdata = {16'hA5C3, 15'h0F0F, ^i[14:3]};
            do_acc("");
        end

        // R4 R10: implementation and feature flags
        for (int i = 0; i < (1 << 12); i++) begin
            cur_level = i[1:0]; acc_write = i[2]; l2_wide_impl = i[3];
            l2_narrow_impl = i[4]; l3_present = i[5]; l2_narrow = i[6];
            l3_narrow = i[7]; l3_wide_impl = i[8]; feat_monitor = i[9];
            feat_narrow_isa = i[10]; l2_enabled = 1; l0_host = 0;
            l3_undef_prio = i[11]; l3_undef = i[0] ^ i[3]; l3_acc_trap = 1;
            l2w_grp_trap = i[11]; l2n_grp_trap = i[11]; l2w_mon_trap = 1; l2n_mon_trap = 1;
            acc_wdata = {31'h1234_5678, ~i[5]};
            do_acc((feat_monitor & feat_narrow_isa) ? "R10" : "R4");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule